// File: doc/BRIEF.md
# Accumulator Processor Core

A compact 16-bit accumulator machine. Instructions and data share one 4096-word memory of 16-bit words, reached through a synchronous port. Every instruction is a single word. The state a program can see is a 12-bit program counter, a 16-bit accumulator and a one-bit extend flag that catches carries and rotate spills. The core also holds a sticky halt state, an interrupt enable, a receive-ready flag and a transmit-ready flag. Each instruction runs as a short sequence:

- an instruction read;
- an optional pointer read when the address is indirect;
- an operand read for memory instructions;
- one execute cycle.

A host system connects its own memory model. It feeds characters with a one-cycle load pulse and acknowledges transmitted characters with a one-cycle pulse. Subroutine calls keep their return address in memory, in the first word of the callee, and return through an indirect branch. An interrupt is taken between instructions. It saves the program counter in word 0 and continues at word 1. The architectural registers are brought out as observation ports for system-level checking.

Top module: `acc_core`

## Requirements
- R1: After reset the program counter, accumulator, extend flag and interrupt enable are 0 and the core is running. The receive flag is clear and the transmit flag is set, so SKO skips and SKI does not.
- R2: For a word whose bits 14..12 are not 7, those bits select the memory operation: 0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ. Bits 11..0 give the address. When bit 15 is set, the effective address is bits 11..0 of the word stored at that address.
- R3: ADD forms the 17-bit sum of accumulator and operand and puts the carry out of bit 15 into the extend flag. AND and LDA leave the extend flag unchanged.
- R4: BSA stores the address of the next instruction into the word at the effective address and continues one word after it. A BUN indirect through that word returns to the caller.
- R5: ISZ writes back the memory word plus one. It skips the next instruction when the written value is 0.
- R6: Register words have bits 15..12 = 0111, with one operation per bit: 0x800 clear AC, 0x400 clear E, 0x200 invert AC, 0x100 invert E, 0x080 rotate right, 0x040 rotate left, 0x020 increment AC. Rotates move the 17-bit ring {E,AC}: rotate right sends AC[0] to E and E to AC[15]; rotate left sends AC[15] to E and E to AC[0].
- R7: Register skip bits: 0x010 skips when AC[15]=0, 0x008 when AC[15]=1, 0x004 when AC=0, 0x002 when E=0.
- R8: Register bit 0x001 halts the core. It stays halted, with no further memory traffic and a frozen PC, until reset.
- R9: Words with bits 15..12 = 1111 are I/O operations:
  - 0x800 copies the received byte into AC[7:0], keeps AC[15:8], and clears the receive flag.
  - 0x400 drives AC[7:0] on the output byte, pulses the output strobe for one cycle, and clears the transmit flag.
  - 0x200 skips when the receive flag is set; 0x100 skips when the transmit flag is set.
  - A load pulse captures the input byte and sets the receive flag. An acknowledge pulse sets the transmit flag.
- R10: When interrupts are enabled and either ready flag is set, the core acts before the next instruction read. It writes the PC into word 0, sets the PC to 1 and clears the interrupt enable.
- R11: I/O bit 0x080 sets the interrupt enable and bit 0x040 clears it. While disabled, set flags cause no interrupt.
- R12: The memory write enable is raised only by STA, BSA, ISZ and interrupt entry, once per such event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, rising edge |
| rstN | input | 1 | synchronous active-low reset |
| memAddr | output | 12 | memory word address |
| memWdata | output | 16 | memory write data |
| memWe | output | 1 | memory write enable |
| memRdata | input | 16 | read data for the address of the previous cycle |
| inData | input | 8 | received character |
| inLoad | input | 1 | one-cycle pulse: capture inData, set receive flag |
| outData | output | 8 | last transmitted character |
| outValid | output | 1 | one-cycle pulse when outData is new |
| outAck | input | 1 | one-cycle pulse: set transmit flag |
| pcValue | output | 12 | program counter |
| acValue | output | 16 | accumulator |
| eValue | output | 1 | extend flag |
| ienValue | output | 1 | interrupt enable |
| halted | output | 1 | core is halted |

## Verification
Short programs exercise the arithmetic and memory paths:
- an addition whose carry leaves bit 15, which separates a 16-bit adder from the 17-bit one;
- an indirect AND, which shows whether the pointer read is actually used;
- chained rotates, which reveal the direction of the ring through E;
- an ISZ counting loop and a call and return, which check write-back and the saved return address;
- skip chains in which the taken and not-taken cases alternate.

Directed programs cover the rest:
- a polled receive and transmit sequence;
- an interrupt that fires right after enabling and returns through word 0;
- an interrupt disabled again before the transmit flag comes back, which must not vector.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 16;
  localparam int CHAR_W = 8;
  localparam int OP_W   = 3;

  localparam logic [OP_W-1:0] OP_AND = 3'd0;
  localparam logic [OP_W-1:0] OP_ADD = 3'd1;
  localparam logic [OP_W-1:0] OP_LDA = 3'd2;
  localparam logic [OP_W-1:0] OP_STA = 3'd3;
  localparam logic [OP_W-1:0] OP_BUN = 3'd4;
  localparam logic [OP_W-1:0] OP_BSA = 3'd5;
  localparam logic [OP_W-1:0] OP_ISZ = 3'd6;
  localparam logic [OP_W-1:0] OP_REG = 3'd7;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_IND, S_INDLD, S_OPRD, S_EXMEM, S_EXREG, S_INTR, S_HALT
  } state_e;

  typedef enum logic [1:0] { A_PC, A_AR, A_ZERO } addrSel_e;
  typedef enum logic [1:0] { W_AC, W_PC, W_INC } wdSel_e;

  typedef struct packed {
    logic     irLoad;
    logic     arFromRd;
    logic     execMem;
    logic     execReg;
    logic     vecLoad;
    logic     inpLoad;
    logic     outLoad;
    logic     ioSkip;
    addrSel_e addrSel;
    wdSel_e   wdSel;
  } strobe_t;
endpackage

// File: rtl/acc_dpath.sv
module acc_dpath
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [CHAR_W-1:0] inData,
  input  logic              inLoad,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] irQ,
  output logic [ADDR_W-1:0] pcQ,
  output logic [DATA_W-1:0] acQ,
  output logic              eQ,
  output logic [CHAR_W-1:0] outData
);
  localparam int PAD_W = DATA_W - ADDR_W;

  logic [ADDR_W-1:0] arQ;
  logic [CHAR_W-1:0] inBufQ;
  logic [DATA_W-1:0] rdInc;
  logic [DATA_W:0]   sum;
  logic [OP_W-1:0]   op;

  assign op    = irQ[14:12];
  assign rdInc = memRdata + {{(DATA_W-1){1'b0}}, 1'b1};
  assign sum   = {1'b0, acQ} + {1'b0, memRdata};

  // register-reference micro-operations applied in a fixed order
  logic [DATA_W-1:0] rAc;
  logic              rE;
  logic              rSkip;
  always_comb begin
    rAc = acQ;
    rE  = eQ;
    if (irQ[11]) rAc = '0;
    if (irQ[10]) rE  = 1'b0;
    if (irQ[9])  rAc = ~rAc;
    if (irQ[8])  rE  = ~rE;
    if (irQ[7])  {rAc, rE} = {rE, rAc};
    if (irQ[6])  {rE, rAc} = {rAc, rE};
    if (irQ[5])  rAc = rAc + {{(DATA_W-1){1'b0}}, 1'b1};
    rSkip = (irQ[4] && !acQ[DATA_W-1]) || (irQ[3] && acQ[DATA_W-1]) ||
            (irQ[2] && (acQ == '0))    || (irQ[1] && !eQ);
  end

  always_comb begin
    unique case (st.addrSel)
      A_AR:    memAddr = arQ;
      A_ZERO:  memAddr = '0;
      default: memAddr = pcQ;
    endcase
    unique case (st.wdSel)
      W_PC:    memWdata = {{PAD_W{1'b0}}, pcQ};
      W_INC:   memWdata = rdInc;
      default: memWdata = acQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ     <= '0;
      arQ     <= '0;
      irQ     <= '0;
      acQ     <= '0;
      eQ      <= 1'b0;
      inBufQ  <= '0;
      outData <= '0;
    end else begin
      if (inLoad) inBufQ <= inData;
      if (st.irLoad) begin
        irQ <= memRdata;
        arQ <= memRdata[ADDR_W-1:0];
        pcQ <= pcQ + 1'b1;
      end
      if (st.arFromRd) arQ <= memRdata[ADDR_W-1:0];
      if (st.vecLoad)  pcQ <= {{(ADDR_W-1){1'b0}}, 1'b1};
      if (st.ioSkip)   pcQ <= pcQ + 1'b1;
      if (st.inpLoad)  acQ[CHAR_W-1:0] <= inBufQ;
      if (st.outLoad)  outData <= acQ[CHAR_W-1:0];
      if (st.execReg) begin
        acQ <= rAc;
        eQ  <= rE;
        if (rSkip) pcQ <= pcQ + 1'b1;
      end
      if (st.execMem) begin
        unique case (op)
          OP_AND: acQ <= acQ & memRdata;
          OP_ADD: {eQ, acQ} <= sum;
          OP_LDA: acQ <= memRdata;
          OP_BUN: pcQ <= arQ;
          OP_BSA: pcQ <= arQ + 1'b1;
          OP_ISZ: if (rdInc == '0) pcQ <= pcQ + 1'b1;
          default: ;
        endcase
      end
    end
  end

  // R6
  cir_ring_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.execReg && irQ == 16'h7080) |=>
      ({eQ, acQ} == {$past(acQ[0]), $past(eQ), $past(acQ[DATA_W-1:1])}));

  // R3
  add_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (st.execMem && op == OP_ADD) |=>
      ({eQ, acQ} == ($past({1'b0, acQ}) + $past({1'b0, memRdata}))));

  // R10
  vec_pc_chk: assert property (@(posedge clk) disable iff (!rstN)
    st.vecLoad |=> (pcQ == {{(ADDR_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] irQ,
  input  logic              inLoad,
  input  logic              outAck,
  output strobe_t           st,
  output logic              memWe,
  output logic              outValid,
  output logic              ienQ,
  output logic              halted
);
  state_e stateQ, stateD;
  logic   inFlagQ, outFlagQ;
  logic   clrIn, clrOut, ienSet, ienClr;
  logic   intReq;

  assign intReq = ienQ && (inFlagQ || outFlagQ);
  assign halted = (stateQ == S_HALT);

  always_comb begin
    st     = '0;
    st.addrSel = A_PC;
    st.wdSel   = W_AC;
    memWe  = 1'b0;
    clrIn  = 1'b0;
    clrOut = 1'b0;
    ienSet = 1'b0;
    ienClr = 1'b0;
    stateD = stateQ;
    unique case (stateQ)
      S_FETCH: begin
        if (intReq) stateD = S_INTR;
        else        stateD = S_DECODE;
      end
      S_DECODE: begin
        st.irLoad = 1'b1;
        if (memRdata[14:12] == OP_REG) stateD = S_EXREG;
        else if (memRdata[15])         stateD = S_IND;
        else                           stateD = S_OPRD;
      end
      S_IND: begin
        st.addrSel = A_AR;
        stateD     = S_INDLD;
      end
      S_INDLD: begin
        st.arFromRd = 1'b1;
        stateD      = S_OPRD;
      end
      S_OPRD: begin
        st.addrSel = A_AR;
        stateD     = S_EXMEM;
      end
      S_EXMEM: begin
        st.execMem = 1'b1;
        st.addrSel = A_AR;
        unique case (irQ[14:12])
          OP_STA: begin memWe = 1'b1; st.wdSel = W_AC;  end
          OP_BSA: begin memWe = 1'b1; st.wdSel = W_PC;  end
          OP_ISZ: begin memWe = 1'b1; st.wdSel = W_INC; end
          default: ;
        endcase
        stateD = S_FETCH;
      end
      S_EXREG: begin
        stateD = S_FETCH;
        if (!irQ[15]) begin
          st.execReg = 1'b1;
          if (irQ[0]) stateD = S_HALT;
        end else begin
          if (irQ[11]) begin st.inpLoad = 1'b1; clrIn  = 1'b1; end
          if (irQ[10]) begin st.outLoad = 1'b1; clrOut = 1'b1; end
          st.ioSkip = (irQ[9] && inFlagQ) || (irQ[8] && outFlagQ);
          ienSet = irQ[7];
          ienClr = irQ[6];
        end
      end
      S_INTR: begin
        st.addrSel = A_ZERO;
        st.wdSel   = W_PC;
        memWe      = 1'b1;
        st.vecLoad = 1'b1;
        ienClr     = 1'b1;
        stateD     = S_FETCH;
      end
      default: stateD = S_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= S_FETCH;
      ienQ     <= 1'b0;
      inFlagQ  <= 1'b0;
      outFlagQ <= 1'b1;
      outValid <= 1'b0;
    end else begin
      stateQ   <= stateD;
      outValid <= st.outLoad;
      if (ienClr)      ienQ <= 1'b0;
      else if (ienSet) ienQ <= 1'b1;
      if (inLoad)      inFlagQ <= 1'b1;
      else if (clrIn)  inFlagQ <= 1'b0;
      if (outAck)      outFlagQ <= 1'b1;
      else if (clrOut) outFlagQ <= 1'b0;
    end
  end

  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> (halted && !memWe));

  // R10
  int_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_INTR) |=> (!ienQ && stateQ == S_FETCH));

  // R11
  ien_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ienQ) |-> $past(stateQ == S_EXREG && irQ[15] && irQ[7]));

  // R12
  write_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [CHAR_W-1:0] inData,
  input  logic              inLoad,
  output logic [CHAR_W-1:0] outData,
  output logic              outValid,
  input  logic              outAck,
  output logic [ADDR_W-1:0] pcValue,
  output logic [DATA_W-1:0] acValue,
  output logic              eValue,
  output logic              ienValue,
  output logic              halted
);
  strobe_t           st;
  logic [DATA_W-1:0] irQ;

  acc_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .memRdata (memRdata),
    .irQ      (irQ),
    .inLoad   (inLoad),
    .outAck   (outAck),
    .st       (st),
    .memWe    (memWe),
    .outValid (outValid),
    .ienQ     (ienValue),
    .halted   (halted)
  );

  acc_dpath dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .memRdata (memRdata),
    .inData   (inData),
    .inLoad   (inLoad),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .irQ      (irQ),
    .pcQ      (pcValue),
    .acQ      (acValue),
    .eQ       (eValue),
    .outData  (outData)
  );
endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 9;

  typedef struct packed {
    logic [0:7][15:0] prog;
    logic [0:3][15:0] data;
    logic [15:0]      expAc;
    logic             expE;
    logic [11:0]      expPc;
    logic [15:0]      expM22;
    logic [3:0]       expWr;
  } vec_t;

  // programs at 0x010, data at 0x020..0x023, word 0 = BUN 010
  localparam vec_t VECS [NV] = '{
    // R2 R3: LDA, ADD with carry out, STA
    '{'{16'h2020,16'h1021,16'h3022,16'h7001,16'h0,16'h0,16'h0,16'h0},
      '{16'h8001,16'h8003,16'h0000,16'h0000}, 16'h0004, 1'b1, 12'h014, 16'h0004, 4'd1},
    // R2: indirect AND through pointer at 021
    '{'{16'h2020,16'h8021,16'h3022,16'h7001,16'h0,16'h0,16'h0,16'h0},
      '{16'hF0F0,16'h0023,16'h0000,16'h3C3C}, 16'h3030, 1'b0, 12'h014, 16'h3030, 4'd1},
    // R6: rotate right twice, rotate left once
    '{'{16'h2020,16'h7080,16'h7080,16'h7040,16'h3022,16'h7001,16'h0,16'h0},
      '{16'h0001,16'h0000,16'h0000,16'h0000}, 16'h0000, 1'b1, 12'h016, 16'h0000, 4'd1},
    // R5: ISZ loop from -3, then complement
    '{'{16'h6020,16'h4010,16'h2020,16'h7200,16'h7001,16'h0,16'h0,16'h0},
      '{16'hFFFD,16'h0000,16'h1234,16'h0000}, 16'hFFFF, 1'b0, 12'h015, 16'h1234, 4'd3},
    // R4: call, increment, return through saved word
    '{'{16'h5020,16'h3022,16'h7001,16'h0,16'h0,16'h0,16'h0,16'h0},
      '{16'h0000,16'h7020,16'hC020,16'h0000}, 16'h0001, 1'b0, 12'h013, 16'h0001, 4'd2},
    // R7: SPA not taken, SNA taken, SZE taken
    '{'{16'h2020,16'h7010,16'h7020,16'h7008,16'h7200,16'h7002,16'h7800,16'h7001},
      '{16'h8000,16'h0000,16'h5555,16'h0000}, 16'h8001, 1'b0, 12'h018, 16'h5555, 4'd0},
    // R6 R7: invert E, clear AC, SZA taken
    '{'{16'h7100,16'h7800,16'h7004,16'h7001,16'h3022,16'h7001,16'h0,16'h0},
      '{16'h0000,16'h0000,16'hFFFF,16'h0000}, 16'h0000, 1'b1, 12'h016, 16'h0000, 4'd1},
    // R1 R9: transmit flag set after reset, SKO taken
    '{'{16'hF100,16'h7001,16'h7001,16'h0,16'h0,16'h0,16'h0,16'h0},
      '{16'h0000,16'h0000,16'h0000,16'h0000}, 16'h0000, 1'b0, 12'h013, 16'h0000, 4'd0},
    // R1 R9: receive flag clear after reset, SKI not taken
    '{'{16'hF200,16'h7001,16'h7001,16'h0,16'h0,16'h0,16'h0,16'h0},
      '{16'h0000,16'h0000,16'h0000,16'h0000}, 16'h0000, 1'b0, 12'h012, 16'h0000, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic        memWe;
  logic [15:0] memRdata;
  logic [7:0]  inData = '0;
  logic        inLoad = 1'b0;
  logic [7:0]  outData;
  logic        outValid;
  logic        outAck = 1'b0;
  logic [11:0] pcValue;
  logic [15:0] acValue;
  logic        eValue;
  logic        ienValue;
  logic        halted;

  logic        ldEn = 1'b0;
  logic [11:0] ldAddr = '0;
  logic [15:0] ldData = '0;
  logic [15:0] mem [0:4095];
  int          wrCount = 0;
  int          ovCount = 0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (ldEn)       mem[ldAddr] <= ldData;
    else if (memWe) mem[memAddr] <= memWdata;
    memRdata <= mem[memAddr];
    if (rstN && memWe) wrCount <= wrCount + 1;
    if (outValid)      ovCount <= ovCount + 1;
  end

  acc_core dut_i (
    .clk(clk), .rstN(rstN), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .memRdata(memRdata), .inData(inData), .inLoad(inLoad), .outData(outData),
    .outValid(outValid), .outAck(outAck), .pcValue(pcValue), .acValue(acValue),
    .eValue(eValue), .ienValue(ienValue), .halted(halted)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic poke(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ldEn = 1'b1; ldAddr = a; ldData = d;
  endtask

  task automatic prepare();
    @(negedge clk);
    rstN = 1'b0;
    for (int a = 0; a < 64; a++) poke(12'(a), 16'h0000);
    poke(12'h000, 16'h4010);
  endtask

  task automatic start();
    @(negedge clk);
    ldEn = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runToHalt(input string tag, input int limit);
    int n = 0;
    while (!halted && n < limit) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " halted"}, 32'(halted), 32'd1);
  endtask

  initial begin
    int wr0;
    int ov0;
    // R1: state held in reset
    prepare();
    @(negedge clk);
    chk("R1 pc", 32'(pcValue), 32'h0);
    chk("R1 ac", 32'(acValue), 32'h0);
    chk("R1 e",  32'(eValue), 32'h0);
    chk("R1 ien", 32'(ienValue), 32'h0);
    chk("R1 running", 32'(halted), 32'h0);

    for (int v = 0; v < NV; v++) begin
      prepare();
      for (int k = 0; k < 8; k++) poke(12'h010 + 12'(k), VECS[v].prog[k]);
      for (int k = 0; k < 4; k++) poke(12'h020 + 12'(k), VECS[v].data[k]);
      start();
      wr0 = wrCount;
      runToHalt($sformatf("vec%0d", v), 400);
      chk($sformatf("vec%0d ac", v), 32'(acValue), 32'(VECS[v].expAc));
      chk($sformatf("vec%0d e", v), 32'(eValue), 32'(VECS[v].expE));
      chk($sformatf("vec%0d pc", v), 32'(pcValue), 32'(VECS[v].expPc));
      chk($sformatf("vec%0d mem022", v), 32'(mem[12'h022]), 32'(VECS[v].expM22));
      // R12: write count per program
      chk($sformatf("vec%0d R12 writes", v), 32'(wrCount - wr0), 32'(VECS[v].expWr));
    end

    // R9: polled receive, echo, transmit flag cleared by OUT
    prepare();
    poke(12'h010, 16'hF200); poke(12'h011, 16'h4010); poke(12'h012, 16'hF800);
    poke(12'h013, 16'hF400); poke(12'h014, 16'hF100); poke(12'h015, 16'h7020);
    poke(12'h016, 16'h7001);
    start();
    ov0 = ovCount;
    repeat (40) @(negedge clk);
    chk("R9 waiting on input", 32'(halted), 32'd0);
    inData = 8'h5A; inLoad = 1'b1;
    @(negedge clk);
    inLoad = 1'b0; inData = 8'h00;
    runToHalt("R9", 400);
    chk("R9 ac", 32'(acValue), 32'h005B);
    chk("R9 pc", 32'(pcValue), 32'h017);
    chk("R9 outData", 32'(outData), 32'h5A);
    chk("R9 outValid pulses", 32'(ovCount - ov0), 32'd1);

    // R10: interrupt right after enabling, return through word 0
    prepare();
    poke(12'h001, 16'h4030); poke(12'h030, 16'hC000);
    poke(12'h010, 16'hF080); poke(12'h011, 16'h7020); poke(12'h012, 16'h7020);
    poke(12'h013, 16'h7001);
    start();
    runToHalt("R10", 400);
    chk("R10 saved pc", 32'(mem[12'h000]), 32'h0011);
    chk("R10 ac", 32'(acValue), 32'h0002);
    chk("R10 pc", 32'(pcValue), 32'h014);
    chk("R10 ien cleared", 32'(ienValue), 32'h0);

    // R11: disabled interrupt ignores returning transmit flag; R8 halt sticks
    prepare();
    poke(12'h001, 16'h7001);
    poke(12'h010, 16'hF400); poke(12'h011, 16'hF080); poke(12'h012, 16'hF040);
    poke(12'h013, 16'hF100); poke(12'h014, 16'h4013); poke(12'h015, 16'h7001);
    start();
    repeat (60) @(negedge clk);
    chk("R11 polling", 32'(halted), 32'd0);
    outAck = 1'b1;
    @(negedge clk);
    outAck = 1'b0;
    runToHalt("R11", 400);
    chk("R11 pc", 32'(pcValue), 32'h016);
    chk("R11 ien", 32'(ienValue), 32'h0);
    chk("R11 word0 untouched", 32'(mem[12'h000]), 32'h4010);
    wr0 = wrCount;
    repeat (20) @(negedge clk);
    chk("R8 still halted", 32'(halted), 32'd1);
    chk("R8 pc frozen", 32'(pcValue), 32'h016);
    chk("R8 no writes", 32'(wrCount - wr0), 32'd0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule